// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the horizontal and vertical raster timing for a parallel RGB panel in generic 16/18-bit TFT mode. Software loads the timing through a simple write port. It writes the sync pulse widths, the first and last-plus-one positions of the visible window on each axis, the pixel and line totals, and a panel configuration word. From these values two counters walk the raster. The block then drives horizontal sync, vertical sync and data-enable, each with its own polarity. It also gives the pixel-clock launch-edge choice and the 18-bit data-width choice to the pixel clock and data path next to it.

All written values first go into a pending copy. The pending copy moves to the working copy only at a frame start, which is either the start after an enable or the wrap from the last pixel of the last line. A frame therefore never changes its timing part-way through.

The block starts on an enable request, but only when the pending panel mode is generic TFT. A disable request does not cut the picture. The block finishes the current frame and then stops. It parks the counters at zero and the sync and enable outputs at their idle levels, and it raises a stopped flag that software can poll. An enable request that arrives while a stop is still waiting cancels that stop.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset the block is stopped (`active`=0, `disabled`=0), both counters read 0, and `hSync`, `vSync`, `de`, `launchFalling` and `wide18` are all 0.
- R2: Write addresses are as follows. Address 0 holds the hsync width in pixels (bits 15:0), address 1 the vsync width in lines, and address 2 the totals (horizontal in 31:16, vertical in 15:0). Address 3 holds the horizontal window (start in 31:16, end in 15:0), address 4 the vertical window in the same layout, and address 5 the configuration. Written values take effect at the next frame start.
- R3: While running, `pixCount` steps by one each clock from 0 to hTotal-1 and then wraps to 0. `lineCount` steps by one on each wrap from 0 to vTotal-1 and otherwise holds.
- R4: Horizontal sync is asserted while pixCount < hsync width. Vertical sync is asserted while lineCount < vsync width.
- R5: `de` is asserted exactly when hStart <= pixCount < hEnd and vStart <= lineCount < vEnd.
- R6: Configuration bit 11 makes hsync active-low, bit 8 makes vsync active-low and bit 9 makes `de` active-low. Bit 10 drives `launchFalling`, bit 7 drives `wide18`, and bits 3:0 are the panel mode, where 0 means generic TFT. An inactive output sits at 1 when its polarity bit is set and at 0 otherwise.
- R7: An `enableReq` while stopped with pending mode 0 starts the block on the next edge. At that point `active`=1, `disabled`=0 and both counters are 0. With a nonzero pending mode, the request is ignored.
- R8: A `disableReq` while running lets the frame finish. On the edge after the last pixel of the last line, `active` drops, `disabled` rises, the counters sit at 0 and the sync and enable outputs go to their idle levels. A `disableReq` while stopped has no effect.
- R9: An `enableReq` while running clears a pending stop, so the next frame follows on without a break.
- R10: A write during a frame does not alter that frame. The new value applies from the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 32 | Register write data |
| enableReq | input | 1 | Start request (single-cycle pulse) |
| disableReq | input | 1 | Stop-at-frame-end request (single-cycle pulse) |
| hSync | output | 1 | Horizontal sync, polarity per configuration |
| vSync | output | 1 | Vertical sync, polarity per configuration |
| de | output | 1 | Data enable, polarity per configuration |
| launchFalling | output | 1 | Data is launched on the falling pixel-clock edge |
| wide18 | output | 1 | Panel data is 18 bits wide |
| pixCount | output | CNT_W | Current pixel position in the line |
| lineCount | output | CNT_W | Current line position in the frame |
| active | output | 1 | Raster is running |
| disabled | output | 1 | A requested stop has completed |

## Verification
The counters and run state are registers. The sync and enable outputs are decoded from them without further delay. So a change requested at a clock edge shows at every output right after that same edge. An enable gives pixel 0 of line 0 one edge later. A stop shows on the edge that follows the last pixel of the last line. A mid-frame write shows only after the wrap that follows it. The bench changes inputs on falling edges and reads every output at the next falling edge. It counts frame positions itself, so each expected value is compared in the cycle where the requirement places it.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_HSW   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_VSW   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_TOT   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_HWIN  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_VWIN  = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_CFG   = 3'd5;

  localparam logic [3:0] MODE_GENERIC = 4'd0;

  typedef struct packed {
    logic       hsLow;
    logic       pclkFall;
    logic       deLow;
    logic       vsLow;
    logic       wide;
    logic [3:0] mode;
  } panelCfg_t;

  typedef struct packed {
    logic load;
    logic clear;
    logic run;
  } ctrlStrobes_t;
endpackage

// File: rtl/lcdt_ctrl.sv
module lcdt_ctrl
  import lcdt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         enableReq,
  input  logic         disableReq,
  input  logic         frameEnd,
  input  logic         modeOk,
  output ctrlStrobes_t strb,
  output logic         running,
  output logic         stopped
);
  logic stopPending;
  logic startNow;
  logic stopWanted;
  logic stopNow;

  assign startNow   = enableReq & ~running & modeOk;
  // an enable request cancels any stop that is waiting
  assign stopWanted = (stopPending | disableReq) & ~enableReq;
  assign stopNow    = running & frameEnd & stopWanted;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running     <= 1'b0;
      stopped     <= 1'b0;
      stopPending <= 1'b0;
    end else begin
      if (startNow) begin
        running <= 1'b1;
        stopped <= 1'b0;
      end else if (stopNow) begin
        running <= 1'b0;
        stopped <= 1'b1;
      end
      stopPending <= running & ~stopNow & stopWanted;
    end
  end

  always_comb begin
    strb.load  = startNow | frameEnd;
    strb.clear = startNow;
    strb.run   = running;
  end
endmodule

// File: rtl/lcdt_datapath.sv
module lcdt_datapath
  import lcdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  ctrlStrobes_t        strb,
  output logic                frameEnd,
  output logic                modeOk,
  output logic                hSync,
  output logic                vSync,
  output logic                de,
  output logic                launchFalling,
  output logic                wide18,
  output logic [CNT_W-1:0]    pixCount,
  output logic [CNT_W-1:0]    lineCount
);
  localparam int HI_LSB = DATA_W / 2;
  localparam logic [CNT_W:0] ONE = (CNT_W + 1)'(1);

  // index 0 = horizontal axis, 1 = vertical axis
  logic [CNT_W-1:0] pSync [2], pTot [2], pBeg [2], pEnd [2];
  logic [CNT_W-1:0] aSync [2], aTot [2], aBeg [2], aEnd [2];
  panelCfg_t        pCfg, aCfg;
  logic             axisLast [2];
  logic             syncOn [2];
  logic             winOn [2];
  logic [CNT_W-1:0] cnt [2];

  assign cnt[0] = pixCount;
  assign cnt[1] = lineCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int a = 0; a < 2; a++) begin
        pSync[a] <= '0; pTot[a] <= '0; pBeg[a] <= '0; pEnd[a] <= '0;
      end
      pCfg <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_HSW:  pSync[0] <= wrData[CNT_W-1:0];
        ADDR_VSW:  pSync[1] <= wrData[CNT_W-1:0];
        ADDR_TOT:  begin
          pTot[0] <= wrData[HI_LSB+CNT_W-1:HI_LSB];
          pTot[1] <= wrData[CNT_W-1:0];
        end
        ADDR_HWIN: begin
          pBeg[0] <= wrData[HI_LSB+CNT_W-1:HI_LSB];
          pEnd[0] <= wrData[CNT_W-1:0];
        end
        ADDR_VWIN: begin
          pBeg[1] <= wrData[HI_LSB+CNT_W-1:HI_LSB];
          pEnd[1] <= wrData[CNT_W-1:0];
        end
        ADDR_CFG:  pCfg <= '{hsLow: wrData[11], pclkFall: wrData[10],
                             deLow: wrData[9], vsLow: wrData[8],
                             wide: wrData[7], mode: wrData[3:0]};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int a = 0; a < 2; a++) begin
        aSync[a] <= '0; aTot[a] <= '0; aBeg[a] <= '0; aEnd[a] <= '0;
      end
      aCfg <= '0;
    end else if (strb.load) begin
      aSync <= pSync; aTot <= pTot; aBeg <= pBeg; aEnd <= pEnd;
      aCfg  <= pCfg;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : gAxis
    assign axisLast[g] = ({1'b0, cnt[g]} + ONE) >= {1'b0, aTot[g]};
    assign syncOn[g]   = cnt[g] < aSync[g];
    assign winOn[g]    = (cnt[g] >= aBeg[g]) && (cnt[g] < aEnd[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixCount  <= '0;
      lineCount <= '0;
    end else if (strb.clear) begin
      pixCount  <= '0;
      lineCount <= '0;
    end else if (strb.run) begin
      if (axisLast[0]) begin
        pixCount  <= '0;
        lineCount <= axisLast[1] ? '0 : lineCount + 1'b1;
      end else begin
        pixCount  <= pixCount + 1'b1;
      end
    end
  end

  assign frameEnd      = strb.run & axisLast[0] & axisLast[1];
  assign modeOk        = (pCfg.mode == MODE_GENERIC);
  assign hSync         = (strb.run & syncOn[0]) ^ aCfg.hsLow;
  assign vSync         = (strb.run & syncOn[1]) ^ aCfg.vsLow;
  assign de            = (strb.run & winOn[0] & winOn[1]) ^ aCfg.deLow;
  assign launchFalling = aCfg.pclkFall;
  assign wide18        = aCfg.wide;
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [31:0]       wrData,
  input  logic              enableReq,
  input  logic              disableReq,
  output logic              hSync,
  output logic              vSync,
  output logic              de,
  output logic              launchFalling,
  output logic              wide18,
  output logic [CNT_W-1:0]  pixCount,
  output logic [CNT_W-1:0]  lineCount,
  output logic              active,
  output logic              disabled
);
  ctrlStrobes_t strb;
  logic         frameEnd;
  logic         modeOk;

  lcdt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enableReq(enableReq), .disableReq(disableReq),
    .frameEnd(frameEnd), .modeOk(modeOk), .strb(strb),
    .running(active), .stopped(disabled)
  );

  lcdt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .frameEnd(frameEnd), .modeOk(modeOk),
    .hSync(hSync), .vSync(vSync), .de(de),
    .launchFalling(launchFalling), .wide18(wide18),
    .pixCount(pixCount), .lineCount(lineCount)
  );
endmodule

// File: rtl/lcd_timing_gen_chk.sv
module lcd_timing_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             active,
  input logic             disabled,
  input logic [CNT_W-1:0] pixCount,
  input logic [CNT_W-1:0] lineCount
);
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> (pixCount == '0 && lineCount == '0)); // R8

  AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (active && $past(active) && pixCount != '0)
      |-> pixCount == $past(pixCount) + 1'b1); // R3

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (active && $past(active) && pixCount != '0)
      |-> lineCount == $past(lineCount)); // R3

  AST_START_ORIGIN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> (pixCount == '0 && lineCount == '0 && !disabled)); // R7

  AST_STOP_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    $rose(disabled) |-> !active); // R8

  AST_RUN_NOT_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    active |-> !disabled); // R9
endmodule

bind lcd_timing_gen lcd_timing_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .active(active), .disabled(disabled),
  .pixCount(pixCount), .lineCount(lineCount)
);

// File: tb/test_lcd_timing_gen.sv
module test_lcd_timing_gen;
  typedef struct packed {
    logic [15:0] hsw, vsw, ht, vt, hs, he, vs, ve;
    logic [31:0] cfg;
  } vec_t;

  localparam int NV = 4;
  localparam vec_t VECS [NV] = '{
    '{16'd2, 16'd1, 16'd12, 16'd6, 16'd4, 16'd10, 16'd2, 16'd5, 32'h000},
    '{16'd1, 16'd2, 16'd10, 16'd5, 16'd3, 16'd8,  16'd3, 16'd4, 32'hA00},
    '{16'd3, 16'd1, 16'd9,  16'd7, 16'd3, 16'd9,  16'd1, 16'd7, 32'h580},
    '{16'd1, 16'd1, 16'd8,  16'd4, 16'd0, 16'd8,  16'd0, 16'd4, 32'hF80}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic enableReq = 1'b0;
  logic disableReq = 1'b0;
  logic hSync, vSync, de, launchFalling, wide18, active, disabled;
  logic [15:0] pixCount, lineCount;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lcd_timing_gen i_lcd_timing_gen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .enableReq(enableReq), .disableReq(disableReq),
    .hSync(hSync), .vSync(vSync), .de(de),
    .launchFalling(launchFalling), .wide18(wide18),
    .pixCount(pixCount), .lineCount(lineCount),
    .active(active), .disabled(disabled)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic prog(input vec_t v);
    wr(3'd0, {16'd0, v.hsw});
    wr(3'd1, {16'd0, v.vsw});
    wr(3'd2, {v.ht, v.vt});
    wr(3'd3, {v.hs, v.he});
    wr(3'd4, {v.vs, v.ve});
    wr(3'd5, v.cfg);
  endtask

  task automatic pulseEnable();
    enableReq = 1'b1;
    @(negedge clk);
    enableReq = 1'b0;
  endtask

  // expected position outputs from the requirements
  task automatic chkPos(input vec_t v, input int p, input int l, input string ctx);
    logic eh, ev, ed;
    eh = (p < int'(v.hsw)) ^ v.cfg[11];
    ev = (l < int'(v.vsw)) ^ v.cfg[8];
    ed = ((p >= int'(v.hs)) && (p < int'(v.he)) &&
          (l >= int'(v.vs)) && (l < int'(v.ve))) ^ v.cfg[9];
    chk({"R3 pix ", ctx}, pixCount, p);
    chk({"R3 line ", ctx}, lineCount, l);
    chk({"R4 hsync ", ctx}, hSync, eh);
    chk({"R4 vsync ", ctx}, vSync, ev);
    chk({"R5 de ", ctx}, de, ed);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    vec_t cv;
    int ht, vt;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 active", active, 0);
    chk("R1 disabled", disabled, 0);
    chk("R1 pix", pixCount, 0);
    chk("R1 line", lineCount, 0);
    chk("R1 outputs", {hSync, vSync, de, launchFalling, wide18}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R8: disable while stopped does nothing
    disableReq = 1'b1; @(negedge clk); disableReq = 1'b0;
    @(negedge clk);
    chk("R8 idle disable active", active, 0);
    chk("R8 idle disable flag", disabled, 0);

    // R7: nonzero panel mode blocks the start
    prog(VECS[0]);
    wr(3'd5, 32'h1);
    pulseEnable();
    chk("R7 mode block active", active, 0);
    chk("R7 mode block pix", pixCount, 0);

    // table of timing vectors, each run for one frame then stopped
    for (int i = 0; i < NV; i++) begin
      cv = VECS[i];
      ht = int'(cv.ht);
      vt = int'(cv.vt);
      prog(cv);
      pulseEnable();
      chk("R7 start active", active, 1);
      chk("R7 start flag", disabled, 0);
      chk("R6 launchFalling", launchFalling, cv.cfg[10]);
      chk("R6 wide18", wide18, cv.cfg[7]);
      for (int n = 0; n < ht * vt; n++) begin
        chkPos(cv, n % ht, n / ht, $sformatf("v%0d n%0d", i, n));
        // R10: mid-frame write of a strange sync width; R8 stop request
        wrEn = (n == ht + 1);
        wrAddr = 3'd0;
        wrData = 32'd5;
        disableReq = (n == ht + 1);
        @(negedge clk);
        wrEn = 1'b0;
        disableReq = 1'b0;
      end
      chk("R8 stopped active", active, 0);
      chk("R8 stopped flag", disabled, 1);
      chk("R8 stopped pix", pixCount, 0);
      chk("R6 idle hsync level", hSync, cv.cfg[11]);
      chk("R6 idle vsync level", vSync, cv.cfg[8]);
      chk("R6 idle de level", de, cv.cfg[9]);
    end

    // R8 disable while stopped after a completed stop
    disableReq = 1'b1; @(negedge clk); disableReq = 1'b0;
    @(negedge clk);
    chk("R8 idle disable keeps flag", disabled, 1);
    chk("R8 idle disable keeps stop", active, 0);

    // R9 / R10 / R2: cancel a stop, change totals mid-frame
    cv = '{16'd1, 16'd1, 16'd8, 16'd3, 16'd2, 16'd6, 16'd0, 16'd3, 32'h0};
    prog(cv);
    pulseEnable();
    for (int n = 0; n < 24; n++) begin
      chkPos(cv, n % 8, n / 8, $sformatf("R10 old total n%0d", n));
      wrEn = (n == 2);
      wrAddr = 3'd2;
      wrData = {16'd10, 16'd3};
      disableReq = (n == 2);
      enableReq = (n == 4);
      @(negedge clk);
      wrEn = 1'b0; disableReq = 1'b0; enableReq = 1'b0;
    end
    chk("R9 cancel keeps running", active, 1);
    chk("R9 cancel flag", disabled, 0);
    chk("R9 new frame pix", pixCount, 0);
    chk("R9 new frame line", lineCount, 0);
    repeat (8) @(negedge clk);
    chk("R2 new total applies pix", pixCount, 8);
    chk("R2 new total applies line", lineCount, 0);
    disableReq = 1'b1; @(negedge clk); disableReq = 1'b0;
    for (int k = 0; k < 40 && !disabled; k++) @(negedge clk);
    chk("R8 final stop flag", disabled, 1);
    chk("R8 final stop line", lineCount, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule